// File: doc/BRIEF.md
# Cascaded Device Selection Unit

This unit sits in each memory chip of a cascade and decides whether that chip answers the command bus. It holds two 16-bit registers: a page identity, assigned once per chip during setup, and a target identity that the host writes to pick a chip. The chip counts as selected when the two registers hold the same value. An all-ones target value selects every chip at once. In that broadcast state the chip still accepts writes, but it will not drive read data.

Page identities are handed out one chip at a time along the chain. A chip accepts a page write only while the enable from the chip before it is high and it has not yet been marked configured. An advance instruction then marks the chip configured, which raises its enable to the next chip. The next page write therefore lands one chip further down the chain. A hardware reset clears everything. A software reset only drops any half-finished instruction and leaves both registers and the configured flag as they are.

An instruction names the target of the next command strobe, and that target is used up by the next strobe. Instruction codes on `instr_code`: 0 no operation, 1 load page, 2 load target, 3 read page, 4 read target, 5 advance. Codes 6 and 7 act as no operation.

Top module: `dcsel_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, the page and target registers are 0000h, the configured flag is clear, `chain_out_en` is low and no instruction is pending. The chip is therefore selected after reset, because 0000h equals 0000h.
- R2: Instruction code 1 followed by a `cmd_wr` strobe loads `cmd_data` into the page register. The load happens only when `chain_in_en` is high during that strobe and the chip is not configured. Loading a page value marks the page as taken.
- R3: The page register never takes the value FFFFh. A page write carrying FFFFh leaves the register unchanged and does not mark the page as taken.
- R4: Instruction code 2 followed by a `cmd_wr` strobe loads `cmd_data` into the target register. This happens whatever the state of `chain_in_en` and of the configured flag.
- R5: `dev_sel` is high exactly when the target register equals the page register, or when the target register is FFFFh.
- R6: While the target register is FFFFh, `rd_en` stays low and `rd_data` is 0000h for every read.
- R7: A `cmd_rd` strobe after instruction code 3 (page) or 4 (target) raises `rd_en` in that same cycle, and `rd_data` carries the named register, provided the chip is selected and not in broadcast. At all other times `rd_en` is low and `rd_data` is 0000h.
- R8: A cycle with `soft_rst` high changes neither register nor the configured flag. It cancels any pending instruction, and every strobe and instruction in that cycle is ignored.
- R9: Instruction code 5 sets the configured flag only if `chain_in_en` is high and a page value has been taken. Once set, the flag stays set until a hardware reset. `chain_out_en` equals the configured flag.
- R10: Once the chip is configured, page writes are ignored.
- R11: A command strobe with no matching pending instruction has no effect. A strobe in the same cycle as an instruction is ignored. Any strobe, or any new instruction, uses up the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| soft_rst | input | 1 | Software reset pulse |
| instr_vld | input | 1 | Instruction strobe |
| instr_code | input | 3 | Instruction code |
| cmd_wr | input | 1 | Command write strobe |
| cmd_rd | input | 1 | Command read strobe |
| cmd_data | input | 16 | Command write data |
| chain_in_en | input | 1 | Enable from the previous chip (high = enabled) |
| dev_sel | output | 1 | Chip is selected |
| rd_en | output | 1 | Read data is being driven |
| rd_data | output | 16 | Read data, zero when not driven |
| chain_out_en | output | 1 | Enable to the next chip |

## Verification
The assertions check the following on every clock cycle:
- the page register never holds FFFFh;
- both registers and the configured flag stay stable across a software reset cycle;
- the page register stays frozen once the chip is configured, and the configured flag never drops;
- an all-ones target forces selection and keeps reads disabled;
- the chain enable never rises without a page having been taken.

Other behaviours can only be shown by the bench's scenarios:
- which register a strobe lands in;
- that an instruction pending is used up by the next strobe;
- that the chain gate blocks page writes;
- that read data matches what was written.

The bench compares these against a model built from the requirements, both in directed sequences and in a long seeded random stream.

// File: rtl/dcsel_pkg.sv
package dcsel_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 3'd0,
    OP_LD_PAGE = 3'd1,
    OP_LD_SEL  = 3'd2,
    OP_RD_PAGE = 3'd3,
    OP_RD_SEL  = 3'd4,
    OP_ADVANCE = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_PAGE  = 3'd1,
    TGT_SEL   = 3'd2,
    TGT_RPAGE = 3'd3,
    TGT_RSEL  = 3'd4
  } tgt_e;

  // Map an instruction code to the target that the next strobe acts on.
  function automatic tgt_e target_of(logic [OP_W-1:0] code);
    case (code)
      OP_LD_PAGE: return TGT_PAGE;
      OP_LD_SEL:  return TGT_SEL;
      OP_RD_PAGE: return TGT_RPAGE;
      OP_RD_SEL:  return TGT_RSEL;
      default:    return TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dcsel_decode.sv
module dcsel_decode
  import dcsel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            instr_vld,
  input  logic [OP_W-1:0] instr_code,
  input  logic            cmd_wr,
  input  logic            cmd_rd,
  output logic            pa_wr_req,
  output logic            ds_wr_req,
  output logic            rd_page_req,
  output logic            rd_sel_req,
  output logic            adv_req
);
  tgt_e pend_q;
  logic strobe_live;
  logic wr_live;
  logic rd_live;

  // A strobe counts only when neither a soft reset nor an instruction shares its cycle.
  assign strobe_live = !soft_rst && !instr_vld;
  assign wr_live     = strobe_live && cmd_wr;
  assign rd_live     = strobe_live && !cmd_wr && cmd_rd;

  assign pa_wr_req   = wr_live && (pend_q == TGT_PAGE);
  assign ds_wr_req   = wr_live && (pend_q == TGT_SEL);
  assign rd_page_req = rd_live && (pend_q == TGT_RPAGE);
  assign rd_sel_req  = rd_live && (pend_q == TGT_RSEL);
  assign adv_req     = !soft_rst && instr_vld && (instr_code == OP_ADVANCE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= TGT_NONE;
    end else if (soft_rst) begin
      pend_q <= TGT_NONE;
    end else if (instr_vld) begin
      pend_q <= target_of(instr_code);
    end else if (cmd_wr || cmd_rd) begin
      pend_q <= TGT_NONE;
    end
  end
endmodule

// File: rtl/dcsel_regs.sv
module dcsel_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pa_wr_req,
  input  logic         ds_wr_req,
  input  logic         adv_req,
  input  logic         chain_in_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pa_q,
  output logic [W-1:0] ds_q,
  output logic         loaded_q,
  output logic         conf_q,
  output logic         pa_take,
  output logic         adv_take
);
  localparam logic [W-1:0] ILLEGAL_PAGE = '1;

  function automatic logic page_legal(logic [W-1:0] v);
    return v != ILLEGAL_PAGE;
  endfunction

  assign pa_take  = pa_wr_req && chain_in_en && !conf_q && page_legal(wdata);
  assign adv_take = adv_req && chain_in_en && loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q     <= '0;
      loaded_q <= 1'b0;
    end else if (pa_take) begin
      pa_q     <= wdata;
      loaded_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_q <= '0;
    end else if (ds_wr_req) begin
      ds_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conf_q <= 1'b0;
    end else if (adv_take) begin
      conf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dcsel_match.sv
module dcsel_match #(
  parameter int W = 16
) (
  input  logic [W-1:0] pa_q,
  input  logic [W-1:0] ds_q,
  input  logic         rd_page_req,
  input  logic         rd_sel_req,
  output logic         dev_sel,
  output logic         bcast,
  output logic         rd_en,
  output logic [W-1:0] rd_data
);
  localparam logic [W-1:0] ALL_DEVICES = '1;

  function automatic logic is_bcast(logic [W-1:0] ds);
    return ds == ALL_DEVICES;
  endfunction

  function automatic logic is_selected(logic [W-1:0] ds, logic [W-1:0] pa);
    return (ds == pa) || is_bcast(ds);
  endfunction

  assign bcast   = is_bcast(ds_q);
  assign dev_sel = is_selected(ds_q, pa_q);
  assign rd_en   = (rd_page_req || rd_sel_req) && dev_sel && !bcast;

  always_comb begin
    rd_data = '0;
    if (rd_en) rd_data = rd_page_req ? pa_q : ds_q;
  end
endmodule

// File: rtl/dcsel_top.sv
module dcsel_top
  import dcsel_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            instr_vld,
  input  logic [OP_W-1:0] instr_code,
  input  logic            cmd_wr,
  input  logic            cmd_rd,
  input  logic [W-1:0]    cmd_data,
  input  logic            chain_in_en,
  output logic            dev_sel,
  output logic            rd_en,
  output logic [W-1:0]    rd_data,
  output logic            chain_out_en
);
  logic         pa_wr_req, ds_wr_req, rd_page_req, rd_sel_req, adv_req;
  logic [W-1:0] pa_q, ds_q;
  logic         loaded_q, conf_q, pa_take, adv_take, bcast;

  dcsel_decode u_decode (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .instr_vld(instr_vld), .instr_code(instr_code),
    .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
    .pa_wr_req(pa_wr_req), .ds_wr_req(ds_wr_req),
    .rd_page_req(rd_page_req), .rd_sel_req(rd_sel_req),
    .adv_req(adv_req)
  );

  dcsel_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .pa_wr_req(pa_wr_req), .ds_wr_req(ds_wr_req), .adv_req(adv_req),
    .chain_in_en(chain_in_en), .wdata(cmd_data),
    .pa_q(pa_q), .ds_q(ds_q), .loaded_q(loaded_q), .conf_q(conf_q),
    .pa_take(pa_take), .adv_take(adv_take)
  );

  dcsel_match #(.W(W)) u_match (
    .pa_q(pa_q), .ds_q(ds_q),
    .rd_page_req(rd_page_req), .rd_sel_req(rd_sel_req),
    .dev_sel(dev_sel), .bcast(bcast), .rd_en(rd_en), .rd_data(rd_data)
  );

  assign chain_out_en = conf_q;
endmodule

// File: rtl/dcsel_chk.sv
module dcsel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         soft_rst,
  input logic         cmd_rd,
  input logic [W-1:0] pa_q,
  input logic [W-1:0] ds_q,
  input logic         loaded_q,
  input logic         conf_q,
  input logic         dev_sel,
  input logic         rd_en,
  input logic [W-1:0] rd_data,
  input logic         chain_out_en
);
  // R3
  page_never_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_q != {W{1'b1}});

  // R8
  soft_reset_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ($stable(pa_q) && $stable(ds_q) && $stable(conf_q)));

  // R10
  configured_freezes_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conf_q |=> $stable(pa_q));

  // R9
  configured_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conf_q |=> conf_q);

  // R9
  chain_needs_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out_en |-> loaded_q);

  // R5
  broadcast_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_q == {W{1'b1}}) |-> dev_sel);

  // R6
  broadcast_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_q == {W{1'b1}}) |-> (!rd_en && rd_data == '0));

  // R7
  read_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (cmd_rd && dev_sel));
endmodule

bind dcsel_top dcsel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_rd(cmd_rd),
  .pa_q(pa_q), .ds_q(ds_q), .loaded_q(loaded_q), .conf_q(conf_q),
  .dev_sel(dev_sel), .rd_en(rd_en), .rd_data(rd_data),
  .chain_out_en(chain_out_en)
);

// File: tb/tb_dcsel_top.sv
`timescale 1ns/1ps
module tb_dcsel_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0, instr_vld = 1'b0, cmd_wr = 1'b0, cmd_rd = 1'b0;
  logic [2:0]  instr_code = 3'd0;
  logic [15:0] cmd_data = 16'h0;
  logic        chain_in_en = 1'b1;
  logic        dev_sel, rd_en, chain_out_en;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;

  // Model state, written from the requirements.
  logic [15:0] m_pa, m_ds;
  logic        m_loaded, m_conf;
  int          m_pend;   // 0 none, 1 page wr, 2 target wr, 3 page rd, 4 target rd
  logic        last_en;
  logic [15:0] last_data;

  always #2 clk = ~clk;

  dcsel_top dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .instr_vld(instr_vld),
    .instr_code(instr_code), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
    .cmd_data(cmd_data), .chain_in_en(chain_in_en), .dev_sel(dev_sel),
    .rd_en(rd_en), .rd_data(rd_data), .chain_out_en(chain_out_en)
  );

  function automatic logic f_sel(logic [15:0] ds, logic [15:0] pa);
    if (ds == 16'hFFFF) return 1'b1;
    return ds == pa;
  endfunction

  function automatic logic f_rden(logic rd, logic wr, logic iv, logic sr, int pend,
                                  logic [15:0] ds, logic [15:0] pa);
    if (!rd || wr || iv || sr) return 1'b0;
    if (pend != 3 && pend != 4) return 1'b0;
    if (ds == 16'hFFFF) return 1'b0;
    return f_sel(ds, pa);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pa = 16'h0; m_ds = 16'h0; m_loaded = 1'b0; m_conf = 1'b0; m_pend = 0;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0; soft_rst = 0; instr_vld = 0; cmd_wr = 0; cmd_rd = 0;
    model_reset();
    repeat (2) @(negedge clk);
    // R1: state while reset is held
    chk("R1 sel", {31'd0, dev_sel}, 32'd1);
    chk("R1 chain", {31'd0, chain_out_en}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic cyc(logic iv, logic [2:0] code, logic wr, logic rd,
                     logic [15:0] d, logic cin, logic sr);
    logic        e_en;
    logic [15:0] e_data;
    @(negedge clk);
    instr_vld = iv; instr_code = code; cmd_wr = wr; cmd_rd = rd;
    cmd_data = d; chain_in_en = cin; soft_rst = sr;
    #1;
    e_en = f_rden(rd, wr, iv, sr, m_pend, m_ds, m_pa);
    e_data = e_en ? ((m_pend == 3) ? m_pa : m_ds) : 16'h0;
    chk("R5 dev_sel", {31'd0, dev_sel}, {31'd0, f_sel(m_ds, m_pa)});
    chk((m_ds == 16'hFFFF) ? "R6 rd_en" : "R7 rd_en", {31'd0, rd_en}, {31'd0, e_en});
    chk("R7 rd_data", {16'd0, rd_data}, {16'd0, e_data});
    chk("R9 chain_out", {31'd0, chain_out_en}, {31'd0, m_conf});
    last_en = rd_en; last_data = rd_data;
    @(posedge clk);
    // Model update.
    if (sr) begin
      m_pend = 0;
    end else if (iv) begin
      if (code == 3'd5 && cin && m_loaded) m_conf = 1'b1;
      m_pend = (code >= 3'd1 && code <= 3'd4) ? int'(code) : 0;
    end else if (wr) begin
      if (m_pend == 1 && cin && !m_conf && d != 16'hFFFF) begin
        m_pa = d; m_loaded = 1'b1;
      end
      if (m_pend == 2) m_ds = d;
      m_pend = 0;
    end else if (rd) begin
      m_pend = 0;
    end
  endtask

  task automatic idle(logic cin);
    cyc(0, 3'd0, 0, 0, 16'h0, cin, 0);
  endtask

  task automatic wr_reg(logic [2:0] code, logic [15:0] d, logic cin);
    cyc(1, code, 0, 0, 16'h0, cin, 0);
    cyc(0, 3'd0, 1, 0, d, cin, 0);
  endtask

  task automatic rd_reg(logic [2:0] code, logic cin);
    cyc(1, code, 0, 0, 16'h0, cin, 0);
    cyc(0, 3'd0, 0, 1, 16'h0, cin, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog R1..: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    hw_reset();
    idle(1);
    // R1: both registers read back as zero after reset
    rd_reg(3'd3, 1); chk("R1 page", {15'd0, last_en, last_data}, {15'd0, 1'b1, 16'h0000});
    rd_reg(3'd4, 1); chk("R1 target", {15'd0, last_en, last_data}, {15'd0, 1'b1, 16'h0000});

    // R2 / R4: load page and target, read page
    wr_reg(3'd1, 16'h0012, 1);
    wr_reg(3'd2, 16'h0012, 1);
    rd_reg(3'd3, 1); chk("R2 page load", {16'd0, last_data}, {16'd0, 16'h0012});
    // R3: all-ones page rejected
    wr_reg(3'd1, 16'hFFFF, 1);
    rd_reg(3'd3, 1); chk("R3 page kept", {16'd0, last_data}, {16'd0, 16'h0012});
    // R9: advance raises chain enable
    cyc(1, 3'd5, 0, 0, 16'h0, 1, 0);
    idle(1); chk("R9 chain set", {31'd0, chain_out_en}, 32'd1);
    // R10: page write after configure ignored
    wr_reg(3'd1, 16'h0055, 1);
    rd_reg(3'd3, 1); chk("R10 page frozen", {16'd0, last_data}, {16'd0, 16'h0012});
    // R8: soft reset cancels pending target and keeps registers
    cyc(1, 3'd2, 0, 0, 16'h0, 1, 0);
    cyc(0, 3'd0, 1, 0, 16'h0099, 1, 1);
    cyc(0, 3'd0, 1, 0, 16'h0099, 1, 0);
    rd_reg(3'd4, 1); chk("R8 target kept", {16'd0, last_data}, {16'd0, 16'h0012});
    chk("R8 chain kept", {31'd0, chain_out_en}, 32'd1);
    // R11: write sharing an instruction cycle ignored, pending used up
    cyc(1, 3'd2, 0, 0, 16'h0, 1, 0);
    cyc(1, 3'd0, 1, 0, 16'h0077, 1, 0);
    cyc(0, 3'd0, 1, 0, 16'h0077, 1, 0);
    rd_reg(3'd4, 1); chk("R11 no stray write", {16'd0, last_data}, {16'd0, 16'h0012});
    // R6: broadcast blocks reads but keeps selection and writes
    wr_reg(3'd2, 16'hFFFF, 1);
    idle(1); chk("R6 bcast sel", {31'd0, dev_sel}, 32'd1);
    rd_reg(3'd4, 1); chk("R6 bcast read", {15'd0, last_en, last_data}, 32'd0);
    wr_reg(3'd2, 16'h0012, 1);
    rd_reg(3'd4, 1); chk("R4 write in bcast", {16'd0, last_data}, {16'd0, 16'h0012});

    // R2 / R4 / R9 with the chain gate closed
    hw_reset();
    wr_reg(3'd1, 16'h0007, 0);
    cyc(1, 3'd5, 0, 0, 16'h0, 0, 0);
    idle(0); chk("R9 gate closed", {31'd0, chain_out_en}, 32'd0);
    rd_reg(3'd3, 0); chk("R2 gated page", {16'd0, last_data}, {16'd0, 16'h0000});
    cyc(1, 3'd5, 0, 0, 16'h0, 1, 0);
    idle(1); chk("R9 needs page", {31'd0, chain_out_en}, 32'd0);
    wr_reg(3'd2, 16'h0007, 0);
    idle(0); chk("R4 gated target", {31'd0, dev_sel}, 32'd0);

    // Random stream against the model.
    hw_reset();
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] d;
      int          r;
      r = int'($urandom_range(0, 99));
      case ($urandom_range(0, 3))
        0: d = 16'hFFFF;
        1: d = m_pa;
        2: d = 16'(($urandom_range(0, 3)));
        default: d = 16'($urandom());
      endcase
      cyc(r < 40, 3'($urandom_range(0, 7)), r >= 40 && r < 70, r >= 60,
          d, $urandom_range(0, 4) != 0, $urandom_range(0, 40) == 0);
      if (i % 1500 == 1499) hw_reset();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule